// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block drives a DDR2 device from reset to a usable state. After reset is released it checks the configuration inputs for CAS latency, additive latency, burst length and termination strength. It then issues a fixed series of mode-register loads and holds a programmed quiet interval. Next it opens a calibration row and runs two write/read calibration rounds. Each command is presented for one cycle on a command-request port for a downstream command encoder to turn into pin activity.

The result of each calibration read comes back from external compare logic as a one-cycle valid strobe with a pass bit. A failed round is repeated, up to a fixed retry limit. When both rounds pass, the sequencer closes all banks with a precharge-all and raises a ready flag. That flag lets the rest of the controller start accepting traffic. The sequence runs once per reset and is never repeated. An unsupported configuration or exhausted retries park the block in an error state with ready held low.

Top module: `ddr2_init_seq`

## Requirements
- R1: On the first rising edge with reset low, given a supported configuration, the block issues on consecutive cycles: a mode-register load to bank 2 with address 0, then a mode-register load to bank 3 with address 0, followed by the three loads of R2 and R3. Command codes on `cmd_op` are 1 = mode-register load, 2 = precharge, 3 = activate, 4 = write, 5 = read.
- R2: The third load targets bank 1. Its address carries the additive latency in bits [5:3] and the termination code bit 0 in address bit 2 and code bit 1 in address bit 6, with all other bits 0 (code 0 = off, 1 = 75 ohm, 2 = 150 ohm, 3 = 50 ohm).
- R3: The fourth and fifth loads target bank 0. Their address holds the burst code in bits [2:0] (2 for length 4, 3 for length 8), the CAS latency in bits [6:4], and WR_CYC-1 in bits [11:9]. Bit 8 (DLL reset) is 1 on the fourth load and 0 on the fifth.
- R4: After the fifth load no command is issued for exactly WAIT_CYCLES cycles. The next cycle carries an activate to bank CAL_BANK, row CAL_ROW.
- R5: After the activate come a write and then a read to column CAL_COL1 on consecutive cycles. On a passing result the block issues a write and then a read to column CAL_COL2 on the next two cycles. A passing second result is followed next cycle by a precharge-all (bank 0, address bit 10 set).
- R6: A `cal_valid` strobe that arrives while no calibration result is awaited has no effect on the command stream.
- R7: A failing result repeats the same round from its write. After RETRY_LIMIT repeats of a round, a further failure raises `err_cal` on the next cycle and stops all commands.
- R8: `init_done` is low until the cycle after the precharge-all, then stays high. No command is issued while it is high.
- R9: A CAS latency outside 3..5, an additive latency above 4, or a burst length other than 4 or 8 raises `err_cfg` on the first edge after reset. No command follows, and `init_done` stays low.
- R10: While reset is high, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cas_lat | input | 3 | CAS latency in cycles |
| cfg_add_lat | input | 3 | Additive latency in cycles |
| cfg_burst_len | input | 4 | Burst length (4 or 8) |
| cfg_odt_sel | input | 2 | Termination strength code |
| cal_valid | input | 1 | Calibration compare result strobe |
| cal_pass | input | 1 | Compare result, 1 = match |
| cmd_valid | output | 1 | Command request present this cycle |
| cmd_op | output | 3 | Command code |
| cmd_bank | output | BA_W | Bank address |
| cmd_addr | output | ADDR_W | Row, column or mode-register value |
| init_done | output | 1 | Initialization and calibration complete |
| err_cfg | output | 1 | Unsupported configuration |
| err_cal | output | 1 | Calibration retries exhausted |

## Verification
A wrong internal state shows up as a wrong command code, bank or address in the very cycle the state is entered, because every command output is registered from the next state. A wait interval that is miscounted moves the activate by one or more cycles, so the first cycle-by-cycle comparison after the interval catches it. A retry counter that is off by one shows as an extra or missing write/read pair, or as `err_cal` rising one round early or late. A bad termination or latency packing shows on the single cycle of the matching load.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [4:0] {
    S_IDLE, S_EMR2, S_EMR3, S_LM1, S_LM2, S_LM3, S_WAIT, S_ACT,
    S_WR1, S_RD1, S_CK1, S_WR2, S_RD2, S_CK2, S_PRE, S_DONE,
    S_ERR_CFG, S_ERR_CAL
  } seq_state_t;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_MRS = 3'd1,
    OP_PRE = 3'd2,
    OP_ACT = 3'd3,
    OP_WR  = 3'd4,
    OP_RD  = 3'd5
  } cmd_op_t;

  typedef struct packed {
    logic [2:0] cas;
    logic [2:0] al;
    logic [3:0] bl;
    logic [1:0] odt;
  } init_cfg_t;

endpackage

// File: rtl/ddr2_mode_pack.sv
module ddr2_mode_pack
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int WR_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  init_cfg_t         cfg_in,
  output logic              cfg_ok,
  output logic [ADDR_W-1:0] mode_val,
  output logic [ADDR_W-1:0] ext_val
);
  localparam logic [2:0] WR_CODE = 3'(WR_CYC - 1);

  logic [ADDR_W-1:0] mode_c, ext_c;

  // Legal ranges are judged on the live inputs so the first step can branch.
  assign cfg_ok = (cfg_in.cas >= 3'd3) && (cfg_in.cas <= 3'd5) &&
                  (cfg_in.al <= 3'd4) &&
                  ((cfg_in.bl == 4'd4) || (cfg_in.bl == 4'd8));

  always_comb begin
    mode_c        = '0;
    mode_c[2:0]   = (cfg_in.bl == 4'd8) ? 3'd3 : 3'd2;
    mode_c[6:4]   = cfg_in.cas;
    mode_c[11:9]  = WR_CODE;
    ext_c         = '0;
    ext_c[2]      = cfg_in.odt[0];
    ext_c[5:3]    = cfg_in.al;
    ext_c[6]      = cfg_in.odt[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_val <= '0;
      ext_val  <= '0;
    end else if (capture) begin
      mode_val <= mode_c;
      ext_val  <= ext_c;
    end
  end

endmodule

// File: rtl/ddr2_wait_ctr.sv
module ddr2_wait_ctr #(
  parameter int WAIT_CYCLES = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(WAIT_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == CW'(WAIT_CYCLES - 1));

endmodule

// File: rtl/ddr2_cmd_decode.sv
module ddr2_cmd_decode
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int BA_W     = 3,
  parameter int CAL_BANK = 0,
  parameter int CAL_ROW  = 0,
  parameter int CAL_COL1 = 0,
  parameter int CAL_COL2 = 8
) (
  input  seq_state_t        state,
  input  logic [ADDR_W-1:0] mode_val,
  input  logic [ADDR_W-1:0] ext_val,
  output logic              valid,
  output logic [2:0]        op,
  output logic [BA_W-1:0]   bank,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] DLL_RST  = ADDR_W'(1) << 8;
  localparam logic [ADDR_W-1:0] PRE_ALL  = ADDR_W'(1) << 10;

  always_comb begin
    valid = 1'b1;
    op    = OP_NOP;
    bank  = '0;
    addr  = '0;
    unique case (state)
      S_EMR2: begin op = OP_MRS; bank = BA_W'(2); end
      S_EMR3: begin op = OP_MRS; bank = BA_W'(3); end
      S_LM1:  begin op = OP_MRS; bank = BA_W'(1); addr = ext_val; end
      S_LM2:  begin op = OP_MRS; addr = mode_val | DLL_RST; end
      S_LM3:  begin op = OP_MRS; addr = mode_val; end
      S_ACT:  begin op = OP_ACT; bank = BA_W'(CAL_BANK); addr = ADDR_W'(CAL_ROW); end
      S_WR1:  begin op = OP_WR;  bank = BA_W'(CAL_BANK); addr = ADDR_W'(CAL_COL1); end
      S_RD1:  begin op = OP_RD;  bank = BA_W'(CAL_BANK); addr = ADDR_W'(CAL_COL1); end
      S_WR2:  begin op = OP_WR;  bank = BA_W'(CAL_BANK); addr = ADDR_W'(CAL_COL2); end
      S_RD2:  begin op = OP_RD;  bank = BA_W'(CAL_BANK); addr = ADDR_W'(CAL_COL2); end
      S_PRE:  begin op = OP_PRE; addr = PRE_ALL; end
      default: valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int BA_W        = 3,
  parameter int WAIT_CYCLES = 200,
  parameter int RETRY_LIMIT = 2,
  parameter int WR_CYC      = 4,
  parameter int CAL_BANK    = 0,
  parameter int CAL_ROW     = 0,
  parameter int CAL_COL1    = 0,
  parameter int CAL_COL2    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_cas_lat,
  input  logic [2:0]        cfg_add_lat,
  input  logic [3:0]        cfg_burst_len,
  input  logic [1:0]        cfg_odt_sel,
  input  logic              cal_valid,
  input  logic              cal_pass,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [BA_W-1:0]   cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              init_done,
  output logic              err_cfg,
  output logic              err_cal
);
  localparam int RW = $clog2(RETRY_LIMIT + 2);

  seq_state_t        st, nxt;
  logic [RW-1:0]     retry, retry_nxt;
  init_cfg_t         cfg_live;
  logic              cfg_ok, wait_expire;
  logic [ADDR_W-1:0] mode_val, ext_val;
  logic              dec_valid;
  logic [2:0]        dec_op;
  logic [BA_W-1:0]   dec_bank;
  logic [ADDR_W-1:0] dec_addr;

  assign cfg_live = '{cas: cfg_cas_lat, al: cfg_add_lat, bl: cfg_burst_len, odt: cfg_odt_sel};

  ddr2_mode_pack #(.ADDR_W(ADDR_W), .WR_CYC(WR_CYC)) u_pack (
    .clk(clk), .rst(rst), .capture(st == S_IDLE), .cfg_in(cfg_live),
    .cfg_ok(cfg_ok), .mode_val(mode_val), .ext_val(ext_val)
  );

  ddr2_wait_ctr #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
    .clk(clk), .rst(rst), .run(st == S_WAIT), .expire(wait_expire)
  );

  ddr2_cmd_decode #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .CAL_BANK(CAL_BANK), .CAL_ROW(CAL_ROW),
    .CAL_COL1(CAL_COL1), .CAL_COL2(CAL_COL2)
  ) u_dec (
    .state(nxt), .mode_val(mode_val), .ext_val(ext_val),
    .valid(dec_valid), .op(dec_op), .bank(dec_bank), .addr(dec_addr)
  );

  always_comb begin
    nxt       = st;
    retry_nxt = retry;
    unique case (st)
      S_IDLE: nxt = cfg_ok ? S_EMR2 : S_ERR_CFG;
      S_EMR2: nxt = S_EMR3;
      S_EMR3: nxt = S_LM1;
      S_LM1:  nxt = S_LM2;
      S_LM2:  nxt = S_LM3;
      S_LM3:  nxt = S_WAIT;
      S_WAIT: if (wait_expire) nxt = S_ACT;
      S_ACT:  nxt = S_WR1;
      S_WR1:  nxt = S_RD1;
      S_RD1:  nxt = S_CK1;
      S_CK1: if (cal_valid) begin
        if (cal_pass) begin
          nxt = S_WR2; retry_nxt = '0;
        end else if (retry == RW'(RETRY_LIMIT)) begin
          nxt = S_ERR_CAL;
        end else begin
          nxt = S_WR1; retry_nxt = retry + 1'b1;
        end
      end
      S_WR2:  nxt = S_RD2;
      S_RD2:  nxt = S_CK2;
      S_CK2: if (cal_valid) begin
        if (cal_pass) begin
          nxt = S_PRE; retry_nxt = '0;
        end else if (retry == RW'(RETRY_LIMIT)) begin
          nxt = S_ERR_CAL;
        end else begin
          nxt = S_WR2; retry_nxt = retry + 1'b1;
        end
      end
      S_PRE:  nxt = S_DONE;
      default: nxt = st;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      retry     <= '0;
      cmd_valid <= 1'b0;
      cmd_op    <= '0;
      cmd_bank  <= '0;
      cmd_addr  <= '0;
      init_done <= 1'b0;
      err_cfg   <= 1'b0;
      err_cal   <= 1'b0;
    end else begin
      st        <= nxt;
      retry     <= retry_nxt;
      cmd_valid <= dec_valid;
      cmd_op    <= dec_op;
      cmd_bank  <= dec_bank;
      cmd_addr  <= dec_addr;
      init_done <= (nxt == S_DONE);
      err_cfg   <= (nxt == S_ERR_CFG);
      err_cal   <= (nxt == S_ERR_CAL);
    end
  end

endmodule

// File: rtl/ddr2_init_chk.sv
module ddr2_init_chk
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int BA_W        = 3,
  parameter int WAIT_CYCLES = 200
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [BA_W-1:0]   cmd_bank,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              init_done,
  input logic              err_cfg,
  input logic              err_cal
);
  logic        armed;
  int unsigned gap;
  logic        last_load;

  assign last_load = cmd_valid && (cmd_op == OP_MRS) && (cmd_bank == '0) && !cmd_addr[8];

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      gap   <= 0;
    end else if (last_load) begin
      armed <= 1'b1;
      gap   <= 0;
    end else if (cmd_valid && cmd_op == OP_ACT) begin
      armed <= 1'b0;
    end else if (armed && gap != 32'hFFFF_FFFF) begin
      gap <= gap + 1;
    end
  end

  AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (rst)
    (armed && gap < WAIT_CYCLES) |-> !cmd_valid); // R4
  AST_ACT_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_ACT) |-> (armed && gap == WAIT_CYCLES)); // R4
  AST_RD_FOLLOWS_WR: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_RD) |-> $past(cmd_valid && cmd_op == OP_WR)); // R5
  AST_DONE_AFTER_PRE: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> $past(cmd_valid && cmd_op == OP_PRE)); // R5
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    init_done |-> !cmd_valid); // R8
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done); // R8
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (err_cfg || err_cal) |-> (!cmd_valid && !init_done)); // R7
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    err_cfg |=> err_cfg); // R9
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    $countones({init_done, err_cfg, err_cal}) <= 1); // R9

endmodule

bind ddr2_init_seq ddr2_init_chk #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .WAIT_CYCLES(WAIT_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .init_done(init_done),
  .err_cfg(err_cfg), .err_cal(err_cal)
);

// File: tb/sim_ddr2_init_seq.sv
module sim_ddr2_init_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 14, BW = 3, WAITC = 200, RLIM = 2, WRC = 4;
  localparam int CBANK = 0, CROW = 0, COL1 = 0, COL2 = 8;

  localparam int P_IDLE = 0, P_EMR2 = 1, P_EMR3 = 2, P_LM1 = 3, P_LM2 = 4, P_LM3 = 5;
  localparam int P_WAIT = 6, P_ACT = 7, P_WR1 = 8, P_RD1 = 9, P_CK1 = 10, P_WR2 = 11;
  localparam int P_RD2 = 12, P_CK2 = 13, P_PRE = 14, P_DONE = 15, P_ERRG = 16, P_ERRC = 17;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] cas = 3'd4, al = 3'd0;
  logic [3:0] bl = 4'd8;
  logic [1:0] odt = 2'd0;
  logic cv = 1'b0, cp = 1'b0;
  logic cmd_valid, init_done, err_cfg, err_cal;
  logic [2:0] cmd_op;
  logic [BW-1:0] cmd_bank;
  logic [AW-1:0] cmd_addr;

  int checks = 0, fails = 0;
  int ph, mw, tries, rsp, wr_seen;
  bit plan[$];
  string pend_tag;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr2_init_seq #(
    .ADDR_W(AW), .BA_W(BW), .WAIT_CYCLES(WAITC), .RETRY_LIMIT(RLIM), .WR_CYC(WRC),
    .CAL_BANK(CBANK), .CAL_ROW(CROW), .CAL_COL1(COL1), .CAL_COL2(COL2)
  ) u0 (
    .clk(clk), .rst(rst), .cfg_cas_lat(cas), .cfg_add_lat(al), .cfg_burst_len(bl),
    .cfg_odt_sel(odt), .cal_valid(cv), .cal_pass(cp), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .init_done(init_done),
    .err_cfg(err_cfg), .err_cal(err_cal)
  );

  function automatic bit cfg_legal();
    return (cas >= 3 && cas <= 5) && (al <= 4) && (bl == 4 || bl == 8);
  endfunction

  function automatic string ph_tag(int p);
    case (p)
      P_EMR2, P_EMR3: return "R1";
      P_LM1:          return "R2";
      P_LM2, P_LM3:   return "R3";
      P_WAIT, P_ACT:  return "R4";
      P_DONE:         return "R8";
      P_ERRC:         return "R7";
      P_ERRG:         return "R9";
      P_IDLE:         return "R10";
      default:        return "R5";
    endcase
  endfunction

  task automatic check(bit ok, string req, string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  task automatic compare();
    int ev, eop, eba, ea, ed, eg, ec, mrv;
    string tag;
    ev = 0; eop = 0; eba = 0; ea = 0; ed = 0; eg = 0; ec = 0;
    mrv = ((bl == 8) ? 3 : 2) | (int'(cas) << 4) | ((WRC - 1) << 9);
    case (ph)
      P_EMR2: begin ev = 1; eop = 1; eba = 2; end
      P_EMR3: begin ev = 1; eop = 1; eba = 3; end
      P_LM1:  begin ev = 1; eop = 1; eba = 1;
                    ea = (int'(al) << 3) | (int'(odt[0]) << 2) | (int'(odt[1]) << 6); end
      P_LM2:  begin ev = 1; eop = 1; ea = mrv | 256; end
      P_LM3:  begin ev = 1; eop = 1; ea = mrv; end
      P_ACT:  begin ev = 1; eop = 3; eba = CBANK; ea = CROW; end
      P_WR1:  begin ev = 1; eop = 4; eba = CBANK; ea = COL1; end
      P_RD1:  begin ev = 1; eop = 5; eba = CBANK; ea = COL1; end
      P_WR2:  begin ev = 1; eop = 4; eba = CBANK; ea = COL2; end
      P_RD2:  begin ev = 1; eop = 5; eba = CBANK; ea = COL2; end
      P_PRE:  begin ev = 1; eop = 2; ea = 1024; end
      P_DONE: ed = 1;
      P_ERRG: eg = 1;
      P_ERRC: ec = 1;
      default: ;
    endcase
    tag = (pend_tag != "") ? pend_tag : ph_tag(ph);
    pend_tag = "";
    if (cmd_valid && cmd_op == 3'd4) wr_seen++;
    if (ev == 0)
      check(!cmd_valid && init_done == ed[0] && err_cfg == eg[0] && err_cal == ec[0], tag,
            $sformatf("ph=%0d got v=%0b done=%0b ecfg=%0b ecal=%0b exp v=0 done=%0d ecfg=%0d ecal=%0d",
                      ph, cmd_valid, init_done, err_cfg, err_cal, ed, eg, ec));
    else
      check(cmd_valid && int'(cmd_op) == eop && int'(cmd_bank) == eba && int'(cmd_addr) == ea &&
            !init_done && !err_cfg && !err_cal, tag,
            $sformatf("ph=%0d got v=%0b op=%0d ba=%0d a=0x%0h exp v=1 op=%0d ba=%0d a=0x%0h",
                      ph, cmd_valid, cmd_op, cmd_bank, cmd_addr, eop, eba, ea));
  endtask

  task automatic step(bit v, bit p);
    case (ph)
      P_IDLE: ph = cfg_legal() ? P_EMR2 : P_ERRG;
      P_EMR2: ph = P_EMR3;
      P_EMR3: ph = P_LM1;
      P_LM1:  ph = P_LM2;
      P_LM2:  ph = P_LM3;
      P_LM3:  begin ph = P_WAIT; mw = 0; end
      P_WAIT: if (mw == WAITC - 1) ph = P_ACT; else mw++;
      P_ACT:  ph = P_WR1;
      P_WR1:  ph = P_RD1;
      P_RD1:  ph = P_CK1;
      P_CK1:  if (v) begin
                if (p) begin ph = P_WR2; tries = 0; end
                else if (tries == RLIM) ph = P_ERRC;
                else begin tries++; ph = P_WR1; end
              end
      P_WR2:  ph = P_RD2;
      P_RD2:  ph = P_CK2;
      P_CK2:  if (v) begin
                if (p) begin ph = P_PRE; tries = 0; end
                else if (tries == RLIM) ph = P_ERRC;
                else begin tries++; ph = P_WR2; end
              end
      P_PRE:  ph = P_DONE;
      default: ;
    endcase
  endtask

  task automatic drive_and_step();
    cv = 1'b0; cp = 1'b0;
    if (ph == P_CK1 || ph == P_CK2) begin
      if (rsp == 2) begin
        cv = 1'b1;
        cp = (plan.size() > 0) ? !plan.pop_front() : 1'b1;
        rsp = 0;
      end else rsp++;
    end else begin
      rsp = 0;
      if ((ph == P_WAIT && (mw == 5 || mw == WAITC - 1)) || ph == P_DONE || ph == P_ACT) begin
        cv = 1'b1; cp = (ph != P_ACT);
        pend_tag = "R6";
      end
    end
    step(cv, cp);
  endtask

  task automatic run(int c, int a, int b, int o, int tail);
    cas = 3'(c); al = 3'(a); bl = 4'(b); odt = 2'(o);
    rst = 1'b1; cv = 1'b0; cp = 1'b0;
    ph = P_IDLE; mw = 0; tries = 0; rsp = 0; wr_seen = 0; pend_tag = "";
    repeat (3) @(negedge clk);
    check(!cmd_valid && cmd_op == 0 && cmd_bank == 0 && cmd_addr == 0 &&
          !init_done && !err_cfg && !err_cal, "R10",
          $sformatf("reset outputs got v=%0b op=%0d done=%0b ecfg=%0b ecal=%0b exp all 0",
                    cmd_valid, cmd_op, init_done, err_cfg, err_cal));
    rst = 1'b0;
    drive_and_step();
    for (int g = 0; g < 2000; g++) begin
      @(negedge clk);
      compare();
      drive_and_step();
      if (ph == P_DONE || ph == P_ERRC || ph == P_ERRG) break;
    end
    for (int t = 0; t < tail; t++) begin
      @(negedge clk);
      compare();
      drive_and_step();
    end
  endtask

  initial begin
    // R1 R2 R3 R4 R5 R6 R8: clean pass, 75 ohm, CL4 AL2 BL8
    plan.delete();
    run(4, 2, 8, 1, 20);
    check(init_done === 1'b1, "R8", $sformatf("final done got %0b exp 1", init_done));
    check(wr_seen == 2, "R5", $sformatf("write count got %0d exp 2", wr_seen));

    // R7: one failure in round 1, two in round 2, 50 ohm, CL3 AL0 BL4
    plan = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    run(3, 0, 4, 3, 10);
    check(init_done === 1'b1, "R7", $sformatf("done after retries got %0b exp 1", init_done));
    check(wr_seen == 5, "R7", $sformatf("write count got %0d exp 5", wr_seen));

    // R7: retries exhausted in round 1, 150 ohm, CL5 AL4 BL8
    plan = '{1'b1, 1'b1, 1'b1};
    run(5, 4, 8, 2, 15);
    check(err_cal === 1'b1 && init_done === 1'b0, "R7",
          $sformatf("cal error got ecal=%0b done=%0b exp 1/0", err_cal, init_done));
    check(wr_seen == 3, "R7", $sformatf("write count got %0d exp 3", wr_seen));

    // R7: retries exhausted in round 2
    plan = '{1'b0, 1'b1, 1'b1, 1'b1};
    run(4, 1, 4, 0, 5);
    check(err_cal === 1'b1, "R7", $sformatf("round2 cal error got %0b exp 1", err_cal));

    // R2 R3: termination off, CL5 AL4 BL4, clean
    plan.delete();
    run(5, 4, 4, 0, 5);
    check(init_done === 1'b1, "R8", $sformatf("final done got %0b exp 1", init_done));

    // R9: unsupported settings
    plan.delete();
    run(6, 0, 8, 1, 8);
    check(err_cfg === 1'b1, "R9", $sformatf("CL6 got ecfg=%0b exp 1", err_cfg));
    run(2, 0, 8, 1, 8);
    check(err_cfg === 1'b1, "R9", $sformatf("CL2 got ecfg=%0b exp 1", err_cfg));
    run(4, 5, 8, 1, 8);
    check(err_cfg === 1'b1, "R9", $sformatf("AL5 got ecfg=%0b exp 1", err_cfg));
    run(4, 0, 5, 1, 8);
    check(err_cfg === 1'b1 && wr_seen == 0, "R9",
          $sformatf("BL5 got ecfg=%0b writes=%0d exp 1/0", err_cfg, wr_seen));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule